// File: doc/BRIEF.md
# Chip-Select Bus Master

This block is the host side of a narrow asynchronous peripheral bus. A requester hands it one 16-bit word access at a time: a word address, write data, a two-bit byte mask and a read/write flag. The block then drives the external bus and returns read data with a one-cycle completion pulse. The bus has a 12-bit word address, a shared bidirectional 16-bit data bus, and these active-low controls: a chip select, a read strobe and one write strobe for each byte lane. An acknowledge line comes back from the slave.

An access ends in one of two ways, and a mode input picks the way for each access. In counted mode the chip select stays low for a programmable number of wait states, and read data is taken when that count runs out. In handshake mode the master waits for the slave's acknowledge. The acknowledge passes through a two-stage synchronizer. After it arrives, the chip select is held low for a programmable extra delay. If no acknowledge comes, a fixed timeout ends the access and raises an error flag. No access starts while the enable input is low.

Top module: `csbus_master`

## Requirements
- R1: After reset, bus_cs_n and bus_oe_n are high, bus_we_n is 2'b11, rsp_done and rsp_error are low, and the master does not drive bus_data.
- R2: While cfg_enable is low, req_ready is low and a request is not accepted. bus_cs_n stays high however long req_valid is held.
- R3: A read (req_write=0) holds bus_oe_n low and bus_we_n at 2'b11 for as long as bus_cs_n is low, and presents req_addr on bus_addr.
- R4: A write holds bus_oe_n high and drives req_wdata on bus_data while bus_cs_n is low. Lane strobe bus_we_n[0] (bits 7:0) is low when req_bmask[0] is 1, and bus_we_n[1] (bits 15:8) is low when req_bmask[1] is 1.
- R5: In counted mode (cfg_ack_mode=0) with wait count W, bus_cs_n is low for exactly W+1 clock cycles. Read data is the bus value on the last of those cycles.
- R6: In handshake mode (cfg_ack_mode=1) with hold count H, bus_cs_n goes high on the (H+4)th rising edge after bus_ack rises. Read data is the bus value when the synchronized acknowledge is first seen.
- R7: In handshake mode with no acknowledge, bus_cs_n is low for TIMEOUT cycles (default 255), and the access then ends with rsp_error high together with rsp_done.
- R8: rsp_done is a single-cycle pulse in the first cycle with bus_cs_n high again. rsp_error is low on every access that ends normally.
- R9: req_ready is high only in idle. Back-to-back requests are separated by exactly one cycle with bus_cs_n high, and a request held during an access is not taken before the current access ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Allows accesses to start |
| cfg_ack_mode | input | 1 | 0: counted wait states, 1: slave acknowledge |
| cfg_wait | input | 8 | Wait-state count W for counted mode |
| cfg_hold | input | 8 | Hold count H after acknowledge |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Word address |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Byte lanes to write, bit 0 = low byte |
| req_ready | output | 1 | Idle and enabled, request will be taken |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | Timeout flag, valid with rsp_done |
| rsp_rdata | output | 16 | Read data of the last read |
| bus_addr | output | 12 | External word address |
| bus_data | inout | 16 | External data bus |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_oe_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 2 | Per-lane write strobes, active low |
| bus_ack | input | 1 | Slave acknowledge, asynchronous |

## Verification
Assertions run on every cycle. They check that the read strobe and the write strobes are never low at the same time, that the strobes and the data driver are active only under a low chip select, that the done pulse lasts one cycle and coincides with the chip-select release, that an error only comes with done, and that a disabled idle master keeps the chip select high. Only the directed scenarios can show the exact access lengths for given wait, hold and timeout values, the delay from acknowledge to release, the captured read data, the lane mapping of the byte mask, and the one-cycle gap between back-to-back accesses.

// File: rtl/csbus_pkg.sv
package csbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_HOLD   = 2'd2
  } csbus_state_t;
endpackage

// File: rtl/csbus_sync.sv
module csbus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/csbus_timer.sv
module csbus_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else            count <= count + 1'b1;
  end
endmodule

// File: rtl/csbus_master.sv
module csbus_master
  import csbus_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 8,
  parameter int TIMEOUT = 255,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_enable,
  input  logic              cfg_ack_mode,
  input  logic [CNT_W-1:0]  cfg_wait,
  input  logic [CNT_W-1:0]  cfg_hold,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_bmask,
  output logic              req_ready,
  output logic              rsp_done,
  output logic              rsp_error,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  inout  wire  [DATA_W-1:0] bus_data,
  output logic              bus_cs_n,
  output logic              bus_oe_n,
  output logic [1:0]        bus_we_n,
  input  logic              bus_ack
);
  localparam logic [CNT_W-1:0] TO_LAST = CNT_W'(TIMEOUT - 1);

  csbus_state_t      state;
  logic              mode_q;
  logic              write_q;
  logic              drive_q;
  logic [DATA_W-1:0] wdata_q;
  logic              ack_s;
  logic              cnt_clr;
  logic [CNT_W-1:0]  cnt;
  logic              take;

  csbus_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .d_async(bus_ack), .q_sync(ack_s)
  );

  // Counter restarts on entering an access and on entering the hold phase
  assign cnt_clr = (state == ST_IDLE) ||
                   (state == ST_ACCESS && mode_q && ack_s);

  csbus_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .clr(cnt_clr), .count(cnt)
  );

  assign req_ready = (state == ST_IDLE) && cfg_enable;
  assign take      = req_ready && req_valid;
  assign bus_data  = drive_q ? wdata_q : 'z;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mode_q    <= 1'b0;
      write_q   <= 1'b0;
      drive_q   <= 1'b0;
      wdata_q   <= '0;
      bus_addr  <= '0;
      bus_cs_n  <= 1'b1;
      bus_oe_n  <= 1'b1;
      bus_we_n  <= 2'b11;
      rsp_done  <= 1'b0;
      rsp_error <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done  <= 1'b0;
      rsp_error <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (take) begin
            state    <= ST_ACCESS;
            mode_q   <= cfg_ack_mode;
            write_q  <= req_write;
            drive_q  <= req_write;
            wdata_q  <= req_wdata;
            bus_addr <= req_addr;
            bus_cs_n <= 1'b0;
            bus_oe_n <= req_write;
            bus_we_n <= req_write ? ~req_bmask : 2'b11;
          end
        end
        ST_ACCESS: begin
          if (!mode_q && cnt == cfg_wait) begin
            if (!write_q) rsp_rdata <= bus_data;
            state    <= ST_IDLE;
            drive_q  <= 1'b0;
            bus_cs_n <= 1'b1;
            bus_oe_n <= 1'b1;
            bus_we_n <= 2'b11;
            rsp_done <= 1'b1;
          end else if (mode_q && ack_s) begin
            if (!write_q) rsp_rdata <= bus_data;
            state <= ST_HOLD;
          end else if (mode_q && cnt == TO_LAST) begin
            state     <= ST_IDLE;
            drive_q   <= 1'b0;
            bus_cs_n  <= 1'b1;
            bus_oe_n  <= 1'b1;
            bus_we_n  <= 2'b11;
            rsp_done  <= 1'b1;
            rsp_error <= 1'b1;
          end
        end
        ST_HOLD: begin
          if (cnt == cfg_hold) begin
            state    <= ST_IDLE;
            drive_q  <= 1'b0;
            bus_cs_n <= 1'b1;
            bus_oe_n <= 1'b1;
            bus_we_n <= 2'b11;
            rsp_done <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3 / R4: read strobe and write strobes never overlap
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !bus_oe_n |-> bus_we_n == 2'b11);

  // R4: strobes and the data driver only inside a chip-select window
  p_drive_in_cs_r4: assert property (@(posedge clk) disable iff (rst)
    (drive_q || bus_we_n != 2'b11 || !bus_oe_n) |-> !bus_cs_n);

  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  // R8: release of chip select coincides with done
  p_done_release_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_cs_n) |-> rsp_done);

  // R7: error only comes with done
  p_err_with_done_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_error |-> rsp_done);

  // R2: a disabled idle master starts nothing
  p_no_start_disabled_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !cfg_enable) |=> bus_cs_n);
endmodule

// File: tb/sim_csbus_master.sv
module sim_csbus_master;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] SLV_WORD = 16'hA5C3;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_enable, cfg_ack_mode;
  logic [7:0]  cfg_wait, cfg_hold;
  logic        req_valid, req_write;
  logic [11:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_bmask;
  logic        req_ready, rsp_done, rsp_error;
  logic [15:0] rsp_rdata;
  logic [11:0] bus_addr;
  wire  [15:0] bus_data;
  logic        bus_cs_n, bus_oe_n;
  logic [1:0]  bus_we_n;
  logic        bus_ack;
  logic [15:0] slv_word;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // slave model drives data while the read strobe is low
  assign bus_data = (!bus_cs_n && !bus_oe_n) ? slv_word : 'z;

  csbus_master u0 (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_ack_mode(cfg_ack_mode),
    .cfg_wait(cfg_wait), .cfg_hold(cfg_hold), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_bmask(req_bmask), .req_ready(req_ready), .rsp_done(rsp_done),
    .rsp_error(rsp_error), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n),
    .bus_we_n(bus_we_n), .bus_ack(bus_ack)
  );

  // bus monitor, sampled away from the clock edge
  int          cs_cnt, hi_run, last_gap, falls;
  logic [1:0]  mon_we;
  logic        mon_oe;
  logic [15:0] mon_data;
  logic [11:0] mon_addr;
  logic        prev_cs = 1'b1;
  always @(negedge clk) begin
    if (!bus_cs_n) begin
      cs_cnt++;
      mon_we = bus_we_n;
      mon_oe = bus_oe_n;
      mon_addr = bus_addr;
      if (bus_we_n != 2'b11) mon_data = bus_data;
      if (prev_cs) begin falls++; last_gap = hi_run; end
      hi_run = 0;
    end else hi_run++;
    prev_cs = bus_cs_n;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start(input logic wr, input logic [11:0] a,
                       input logic [15:0] d, input logic [1:0] m);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cs_cnt = 0;
    req_write = wr; req_addr = a; req_wdata = d; req_bmask = m;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!rsp_done && n < 400) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    chk(bus_cs_n && bus_oe_n && bus_we_n == 2'b11, "R1 bus idle", {bus_cs_n, bus_oe_n, bus_we_n}, 4'hF);
    chk(!rsp_done && !rsp_error, "R1 rsp low", {rsp_done, rsp_error}, 0);
  endtask

  task automatic t_disabled();
    cfg_enable = 1'b0;
    @(negedge clk);
    cs_cnt = 0;
    req_write = 1'b0; req_valid = 1'b1;
    repeat (6) @(negedge clk);
    chk(!req_ready, "R2 ready low", req_ready, 0);
    chk(cs_cnt == 0, "R2 no access", cs_cnt, 0);
    req_valid = 1'b0;
    cfg_enable = 1'b1;
  endtask

  task automatic t_fixed_read(input int w, input logic [15:0] word);
    cfg_ack_mode = 1'b0; cfg_wait = 8'(w); slv_word = word;
    start(1'b0, 12'h3A5, 16'h0, 2'b11);
    wait_done();
    chk(rsp_done && !rsp_error, "R8 done no error", {rsp_done, rsp_error}, 2);
    chk(cs_cnt == w + 1, "R5 cs length", cs_cnt, w + 1);
    chk(rsp_rdata == word, "R5 read data", rsp_rdata, word);
    chk(!mon_oe && mon_we == 2'b11, "R3 read strobes", {mon_oe, mon_we}, 3);
    chk(mon_addr == 12'h3A5, "R3 address", mon_addr, 12'h3A5);
  endtask

  task automatic t_fixed_write(input logic [1:0] m, input logic [15:0] d);
    cfg_ack_mode = 1'b0; cfg_wait = 8'd2;
    start(1'b1, 12'h011, d, m);
    wait_done();
    chk(cs_cnt == 3, "R5 write cs length", cs_cnt, 3);
    chk(mon_we == ~m, "R4 lane strobes", mon_we, ~m);
    chk(mon_oe, "R4 oe high", mon_oe, 1);
    chk(mon_data == d, "R4 write data", mon_data, d);
  endtask

  task automatic t_ack(input int h, input int dly, input logic [15:0] word);
    int n = 0;
    cfg_ack_mode = 1'b1; cfg_hold = 8'(h); slv_word = word;
    start(1'b0, 12'h0F0, 16'h0, 2'b11);
    repeat (dly) @(negedge clk);
    bus_ack = 1'b1;
    while (n < 300) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (bus_cs_n) break;
    end
    chk(n == h + 4, "R6 ack to release", n, h + 4);
    chk(rsp_done && !rsp_error, "R6 done on release", {rsp_done, rsp_error}, 2);
    chk(rsp_rdata == word, "R6 read data", rsp_rdata, word);
    bus_ack = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_timeout();
    cfg_ack_mode = 1'b1;
    start(1'b1, 12'h222, 16'h1234, 2'b11);
    wait_done();
    chk(rsp_done && rsp_error, "R7 timeout error", {rsp_done, rsp_error}, 3);
    chk(cs_cnt == 255, "R7 timeout length", cs_cnt, 255);
    @(negedge clk);
    chk(!rsp_done, "R8 pulse one cycle", rsp_done, 0);
  endtask

  task automatic t_back2back();
    cfg_ack_mode = 1'b0; cfg_wait = 8'd3;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    falls = 0; cs_cnt = 0;
    req_write = 1'b1; req_addr = 12'h055; req_wdata = 16'hBEEF; req_bmask = 2'b11;
    req_valid = 1'b1;
    @(negedge clk);
    chk(!req_ready, "R9 busy not ready", req_ready, 0);
    wait_done();
    chk(req_ready && falls == 1, "R9 held request waits", falls, 1);
    @(negedge clk);
    wait_done();
    req_valid = 1'b0;
    chk(falls == 2, "R9 two accesses", falls, 2);
    chk(last_gap == 1, "R9 one-cycle gap", last_gap, 1);
    chk(cs_cnt == 8, "R9 both lengths", cs_cnt, 8);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_enable = 1'b1; cfg_ack_mode = 1'b0;
    cfg_wait = 8'd6; cfg_hold = 8'd6;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    req_bmask = 2'b00; bus_ack = 1'b0; slv_word = SLV_WORD;
    cs_cnt = 0; hi_run = 0; last_gap = 0; falls = 0;
    mon_we = 2'b11; mon_oe = 1'b1; mon_data = '0; mon_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_fixed_read(6, 16'hA5C3);
    t_fixed_read(0, 16'h5A0F);
    t_fixed_write(2'b01, 16'h00C7);
    t_fixed_write(2'b10, 16'h9900);
    t_ack(6, 3, 16'h7E81);
    t_ack(0, 5, 16'h0102);
    t_timeout();
    t_back2back();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule